// File: doc/BRIEF.md
# Single-Slave SPI Word Master

A memory-mapped SPI master that exchanges one 8-bit or 16-bit word with a single slave per launch. Software programs a configuration word that sets the word size and the serial clock divider, raises the chip select through the control word, and writes the outgoing word into the transmit register. That write starts a full-duplex exchange in SPI mode 0: the serial clock idles low, outgoing bits change on its falling edge and incoming bits are sampled on its rising edge, most significant bit first.

When the last incoming bit is captured, the received word appears in the receive register and a completion flag in the cause register becomes nonzero. Software polls that flag as its ready indication and clears it by writing zero before sending the next word. The serial clock is derived from the system clock by an even divide ratio between 4 and 30, encoded as a 5-bit prescale code of 16 plus half the ratio.

Top module: `spi_word_master`

## Requirements
- R1: After reset every register reads zero, the active-low select output is high, the serial clock is low and the cause register reads zero.
- R2: Bit 0 of the control register (offset 0x00) drives the select line: writing 1 pulls the active-low select output low in the next cycle, writing 0 returns it high.
- R3: With configuration bit 5 clear, a write to the transmit register (offset 0x08) sends bits 7:0 MSB first, and the receive register (offset 0x0C) afterwards holds the 8 received bits in 7:0 with bits 15:8 zero.
- R4: With configuration bit 5 set, a transfer sends and receives 16 bits, bit 15 first, and the receive register holds the full word in bits 15:0.
- R5: The configuration low 5 bits (offset 0x04) hold a prescale code; for codes 0x12 to 0x1F the serial clock stays high for (code - 16) system clocks per bit and low equally long, and any code below 0x12 behaves as code 0x12.
- R6: The cause register (offset 0x10) reads 1 once the last bit has been captured, and a write with bit 0 clear returns it to zero; a write with bit 0 set leaves it unchanged.
- R7: Control bit 1 reads 1 while a transfer is in progress, and a transmit write during that time is ignored: neither the outgoing data nor the transmit register readback changes.
- R8: The serial clock is low whenever no transfer is in progress, and the outgoing data line never changes while the serial clock is high.
- R9: The configuration register reads back its 6 written bits, the transmit register reads back the last accepted word, and unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte offset of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Outgoing serial data |
| spi_miso | input | 1 | Incoming serial data |
| spi_ss_n | output | 1 | Active-low slave select |

## Verification
The bench sweeps the prescale codes at both ends of the valid range and below it, because a divider that mishandled the offset of 16 or the clamp would stretch or shrink the serial clock high time by whole system clocks, which the bench counts exactly. It mixes 8-bit and 16-bit words with all-ones, all-zeros and single-end-bit patterns, so a design that shifted the wrong end first, left stale upper bits in 8-bit mode or dropped the final bit would return a corrupted word. A second transmit write issued mid-transfer targets a design that restarts or reloads, which would show up as a different word at the slave. Clearing and non-clearing writes to the cause register catch a flag that is cleared on any write or never cleared.

// File: rtl/spi_word_master.sv
module spi_word_master #(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          spi_sclk,
  output logic          spi_mosi,
  input  logic          spi_miso,
  output logic          spi_ss_n
);
  localparam logic [AW-1:0] A_CTRL  = AW'(5'h00);
  localparam logic [AW-1:0] A_CFG   = AW'(5'h04);
  localparam logic [AW-1:0] A_TX    = AW'(5'h08);
  localparam logic [AW-1:0] A_RX    = AW'(5'h0C);
  localparam logic [AW-1:0] A_CAUSE = AW'(5'h10);
  localparam logic [4:0]    MIN_CODE = 5'h12;

  logic        ss_en_q, busy_q, cause_q, sclk_q, last_q;
  logic [5:0]  cfg_q;
  logic [15:0] tx_q, rx_q, shreg_q, rxsh_q;
  logic [4:0]  bitcnt_q;
  logic [3:0]  divcnt_q;

  logic [3:0]  half;
  logic        wide, launch, tick;
  logic [15:0] rx_next;

  assign wide    = cfg_q[5];
  assign half    = (cfg_q[4:0] < MIN_CODE) ? 4'd2 : 4'(cfg_q[4:0] - 5'd16);
  assign tick    = divcnt_q >= half - 4'd1;
  assign launch  = reg_wr && reg_addr == A_TX && !busy_q;
  assign rx_next = {rxsh_q[14:0], spi_miso};

  assign spi_sclk = sclk_q;
  assign spi_mosi = shreg_q[15];
  assign spi_ss_n = ~ss_en_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata[1:0] = {busy_q, ss_en_q};
      A_CFG:   reg_rdata[5:0] = cfg_q;
      A_TX:    reg_rdata[15:0] = tx_q;
      A_RX:    reg_rdata[15:0] = rx_q;
      A_CAUSE: reg_rdata[0] = cause_q;
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_en_q  <= 1'b0;
      cfg_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
      cause_q  <= 1'b0;
      busy_q   <= 1'b0;
      sclk_q   <= 1'b0;
      last_q   <= 1'b0;
      shreg_q  <= '0;
      rxsh_q   <= '0;
      bitcnt_q <= '0;
      divcnt_q <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          A_CTRL:  ss_en_q <= reg_wdata[0];
          A_CFG:   cfg_q   <= reg_wdata[5:0];
          A_CAUSE: if (!reg_wdata[0]) cause_q <= 1'b0;
          default: ;
        endcase
      end
      if (launch) begin
        tx_q     <= reg_wdata[15:0];
        busy_q   <= 1'b1;
        sclk_q   <= 1'b0;
        last_q   <= 1'b0;
        divcnt_q <= '0;
        rxsh_q   <= '0;
        bitcnt_q <= wide ? 5'd16 : 5'd8;
        shreg_q  <= wide ? reg_wdata[15:0] : {reg_wdata[7:0], 8'h00};
      end else if (busy_q) begin
        if (tick) begin
          divcnt_q <= '0;
          if (!sclk_q) begin
            sclk_q   <= 1'b1;
            rxsh_q   <= rx_next;
            bitcnt_q <= bitcnt_q - 5'd1;
            if (bitcnt_q == 5'd1) begin
              rx_q    <= wide ? rx_next : {8'h00, rx_next[7:0]};
              cause_q <= 1'b1;
              last_q  <= 1'b1;
            end
          end else begin
            sclk_q <= 1'b0;
            if (last_q) busy_q  <= 1'b0;
            else        shreg_q <= {shreg_q[14:0], 1'b0};
          end
        end else begin
          divcnt_q <= divcnt_q + 4'd1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_word_master_chk.sv
module spi_word_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [4:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        spi_sclk,
  input logic        spi_mosi,
  input logic        spi_ss_n,
  input logic        busy,
  input logic        cause
);
  p_idle_sclk_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spi_sclk);

  p_mosi_quiet_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spi_mosi) |-> !spi_sclk);

  p_select_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 5'h00) |=> spi_ss_n == !$past(reg_wdata[0]));

  p_cause_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 5'h10 && !reg_wdata[0] && !busy) |=> !cause);

  p_cause_rise_in_xfer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cause) |-> busy);

  p_busy_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !spi_sclk && reg_wr && reg_addr == 5'h08) |=> busy);
endmodule

bind spi_word_master spi_word_master_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .spi_sclk  (spi_sclk),
  .spi_mosi  (spi_mosi),
  .spi_ss_n  (spi_ss_n),
  .busy      (busy_q),
  .cause     (cause_q)
);

// File: tb/spi_word_master_tb_top.sv
module spi_word_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        spi_sclk, spi_mosi, spi_ss_n;
  logic        spi_miso;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] slv_tx = '0;
  logic [15:0] slv_rx = '0;
  int          high_cnt = 0;

  always #2.5 clk = ~clk;

  spi_word_master dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_ss_n(spi_ss_n)
  );

  assign spi_miso = slv_tx[15];
  always @(posedge spi_sclk) slv_rx <= {slv_rx[14:0], spi_mosi};
  always @(negedge spi_sclk) slv_tx <= {slv_tx[14:0], 1'b0};
  always @(posedge clk) if (spi_sclk) high_cnt <= high_cnt + 1;

  // {wide, code, tx word, slave word}
  localparam int NV = 6;
  localparam logic [37:0] VEC [NV] = '{
    {1'b0, 5'h12, 16'h00A5, 16'h003C},
    {1'b1, 5'h12, 16'hBEEF, 16'h1234},
    {1'b0, 5'h1F, 16'h0081, 16'h007E},
    {1'b1, 5'h15, 16'h8001, 16'hF00D},
    {1'b0, 5'h03, 16'h00FF, 16'h0000},
    {1'b1, 5'h1A, 16'h0000, 16'hFFFF}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_done();
    logic [31:0] v;
    v = 0;
    while (v[0] == 1'b0) rd(5'h10, v);
    v = 32'h2;
    while (v[1] == 1'b1) rd(5'h00, v);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(5'h00, v); check("R1 ctrl", v, 0);
    rd(5'h04, v); check("R1 cfg", v, 0);
    rd(5'h0C, v); check("R1 rx", v, 0);
    rd(5'h10, v); check("R1 cause", v, 0);
    check("R1 ss_n", 32'(spi_ss_n), 1);
    check("R1 sclk", 32'(spi_sclk), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 select control
    wr(5'h00, 1); check("R2 ss_n low", 32'(spi_ss_n), 0);
    wr(5'h00, 0); check("R2 ss_n high", 32'(spi_ss_n), 1);

    // table walk: R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      logic        w;
      logic [4:0]  code;
      logic [15:0] tx, sw, mask;
      int          hf, nb;
      {w, code, tx, sw} = VEC[i];
      mask = w ? 16'hFFFF : 16'h00FF;
      hf = (code < 5'h12) ? 2 : int'(code) - 16;
      nb = w ? 16 : 8;
      wr(5'h04, {26'd0, w, code});
      wr(5'h00, 1);
      wr(5'h10, 0);
      @(negedge clk);
      slv_tx = w ? sw : {sw[7:0], 8'h00};
      high_cnt = 0;
      wr(5'h08, {16'd0, tx});
      wait_done();
      rd(5'h0C, v); check(w ? "R4 rx word" : "R3 rx word", v, {16'd0, sw & mask});
      check(w ? "R4 slave got" : "R3 slave got", {16'd0, slv_rx & mask}, {16'd0, tx & mask});
      check("R5 sclk high cycles", high_cnt, hf * nb);
      rd(5'h10, v); check("R6 cause set", v, 1);
      check("R8 sclk idle", 32'(spi_sclk), 0);
      wr(5'h00, 0);
    end

    // R6 write of one keeps, write of zero clears
    wr(5'h10, 1); rd(5'h10, v); check("R6 cause kept", v, 1);
    wr(5'h10, 0); rd(5'h10, v); check("R6 cause cleared", v, 0);

    // R7 busy and ignored write
    wr(5'h04, 32'h12);
    @(negedge clk); slv_tx = 16'h5A00;
    wr(5'h08, 32'h00C3);
    rd(5'h00, v); check("R7 busy", {31'd0, v[1]}, 1);
    wr(5'h08, 32'h0011);
    rd(5'h08, v); check("R7 tx readback", v, 32'h00C3);
    wait_done();
    check("R7 slave got original", {24'd0, slv_rx[7:0]}, 32'hC3);
    rd(5'h0C, v); check("R7 rx", v, 32'h5A);

    // R9 readback and unmapped
    wr(5'h04, 32'hFFFF_FFF7);
    rd(5'h04, v); check("R9 cfg readback", v, 32'h37);
    rd(5'h14, v); check("R9 unmapped", v, 0);
    rd(5'h02, v); check("R9 unmapped low", v, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule